// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block turns the eight shared PCI interrupt request levels (PIRQ A to H) and one power-management interrupt level (SCI) into a 24-bit vector of system interrupt lines. Lines 0 to 15 feed both the legacy interrupt controller and the I/O interrupt controller. Lines 16 to 23 feed only the I/O interrupt controller. Every PIRQ drives two lines at once. One is a fixed high line with its own number. The other is a low line that software picks through a route byte, and software can also switch that path off. When several sources land on the same low line, the line carries the OR of their levels. The SCI can be steered onto one of five lines. When it is moved while asserted, it leaves the old line before it appears on the new one.

A second, combinational function tells the bus fabric which PIRQ a device pin uses, given the device slot number and the pin (INTA to INTD). The upper slots have override words that software can write. The lower slots follow a fixed rotation. Software writes all routing state through one simple write port. A write carries a kind, an index and data.

Top module: `pirq_router`

## Requirements
- R1: After reset, `gsi_out` is all zero. Every route byte is 0x80, which means its low-line path is disabled. The SCI select code is 0, which steers the SCI to line 9. Every slot override word is 0x3210.
- R2: `gsi_out[16+n]` follows `pirq_lvl[n]` one clock later. The route byte of PIRQ n has no effect on this line.
- R3: A write with `cfg_wr_kind`=0 stores `cfg_wr_data[7:0]` as the route byte of PIRQ `cfg_wr_idx`. Bits [3:0] of that byte give the low line number, and bit 7 set disables that PIRQ's low-line path.
- R4: Each low line g (0..15) is driven, one clock after its inputs, with the OR of every PIRQ whose route byte is enabled and has a line field equal to g. Several PIRQs can share one line.
- R5: A write with `cfg_wr_kind`=1 stores `cfg_wr_data[2:0]` as the SCI select code. The codes map as follows: 0 to line 9, 1 to line 10, 2 to line 11, 4 to line 20, 5 to line 21. Codes 3, 6 and 7 steer the SCI to no line. The SCI level is ORed into the selected line.
- R6: The SCI may be asserted when a write changes the select code. In that case the old line stays high for one more clock, then for one clock the SCI drives no line, and then it appears on the new line.
- R7: For slots 0 to 24, `map_pirq` = ((slot + pin) mod 4) + 4, with the pin coded 0=INTA to 3=INTD. These slots never use PIRQ A to D.
- R8: For slots 25 to 29 and 31, `map_pirq` is taken from that slot's override word. Pin p uses bits [4p+2:4p]. A write with `cfg_wr_kind`=2 and `cfg_wr_idx`=slot-25 stores `cfg_wr_data` into that word.
- R9: Slot 30 always maps pin p to PIRQ 4+p. A write to its override index (5) has no effect, and so does a slot write to index 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Routing register write strobe |
| cfg_wr_kind | input | 2 | Write target: 0 route byte, 1 SCI select, 2 slot override word |
| cfg_wr_idx | input | 3 | PIRQ index, or slot minus 25 |
| cfg_wr_data | input | 16 | Write data |
| pirq_lvl | input | 8 | PIRQ A..H levels, bit n is PIRQ n |
| sci_lvl | input | 1 | SCI level |
| map_slot | input | 5 | Device slot for the pin lookup |
| map_pin | input | 2 | Device pin, 0=INTA..3=INTD |
| map_pirq | output | 3 | PIRQ used by that slot and pin |
| gsi_out | output | 24 | Registered system interrupt line levels |

## Verification
The hardest case to reach is an SCI that is moved while it is asserted. The one-clock gap lasts only a single cycle, and only a write that lands while `sci_lvl` is high opens it. The bench holds the SCI high, writes a new select code, and samples the output on three clocks in a row: old line, no line, new line. It then repeats the move into a reserved code and back out of it. The table run sets up two enabled PIRQs sharing one low line, together with a disabled PIRQ whose field points at the SCI's line. This shows that sharing and masking act on the same line at the same time.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  typedef enum logic [1:0] {
    WR_ROUTE = 2'd0,
    WR_SCI   = 2'd1,
    WR_SLOT  = 2'd2
  } wr_kind_e;

  localparam logic [7:0]  ROUTE_RESET = 8'h80;
  localparam logic [15:0] SLOT_RESET  = 16'h3210;
  localparam logic [2:0]  SCI_RESET   = 3'd0;

  typedef struct packed {
    logic       vld;
    logic [4:0] line;
  } sci_dest_t;

  // SCI select code to destination line; reserved codes give no line.
  function automatic sci_dest_t sci_code_dest(input logic [2:0] code);
    sci_dest_t d;
    d.vld  = 1'b1;
    unique case (code)
      3'd0:    d.line = 5'd9;
      3'd1:    d.line = 5'd10;
      3'd2:    d.line = 5'd11;
      3'd4:    d.line = 5'd20;
      3'd5:    d.line = 5'd21;
      default: begin d.vld = 1'b0; d.line = 5'd0; end
    endcase
    return d;
  endfunction

  // Rotating default: upper PIRQ bank, offset by slot plus pin.
  function automatic logic [2:0] rotate_pirq(input logic [4:0] slot, input logic [1:0] pin);
    logic [1:0] sum;
    sum = slot[1:0] + pin;
    return {1'b1, sum};
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int IDX_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [7:0]               wr_byte,
  input  logic                     sci_lvl,
  output logic [NUM_PIRQ-1:0][7:0] route_q,
  output logic [2:0]               sci_code_q,
  output logic                     sci_gap_q
);

  logic route_wr, sci_wr, sci_moves;
  assign route_wr  = wr_en && (wr_kind == WR_ROUTE);
  assign sci_wr    = wr_en && (wr_kind == WR_SCI);
  assign sci_moves = sci_wr && (wr_byte[2:0] != sci_code_q);

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   route_q[n] <= ROUTE_RESET;
      else if (route_wr && wr_idx == IDX_W'(n))     route_q[n] <= wr_byte;
    end

    AST_ROUTE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (route_wr && wr_idx == IDX_W'(n)) |=> route_q[n] == $past(wr_byte)); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_code_q <= SCI_RESET;
      sci_gap_q  <= 1'b0;
    end else begin
      if (sci_wr) sci_code_q <= wr_byte[2:0];
      sci_gap_q <= sci_moves && sci_lvl;
    end
  end

  AST_GAP_ONLY_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    sci_gap_q |-> $past(sci_lvl) && $past(sci_wr)); // R6

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
  import pirq_router_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter int OVR_BASE   = 25,
  parameter int OVR_CNT    = 7,
  parameter int FIXED_SLOT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [4:0]       map_slot,
  input  logic [1:0]       map_pin,
  output logic [2:0]       map_pirq
);

  localparam int FIXED_IDX = FIXED_SLOT - OVR_BASE;

  logic        slot_wr;
  logic [15:0] ovr_q [OVR_CNT];
  assign slot_wr = wr_en && (wr_kind == WR_SLOT);

  for (genvar i = 0; i < OVR_CNT; i++) begin : g_ovr
    if (i == FIXED_IDX) begin : g_fixed
      // fixed bridge slot: no storage, pins go to the upper bank in order
      assign ovr_q[i] = 16'h7654;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 ovr_q[i] <= SLOT_RESET;
        else if (slot_wr && wr_idx == IDX_W'(i))    ovr_q[i] <= wr_data;
      end
    end
  end

  logic        in_ovr;
  logic [15:0] sel_word;
  int          ovr_off;

  always_comb begin
    in_ovr   = (int'(map_slot) >= OVR_BASE) && (int'(map_slot) < OVR_BASE + OVR_CNT);
    ovr_off  = in_ovr ? int'(map_slot) - OVR_BASE : 0;
    sel_word = ovr_q[ovr_off];
    if (in_ovr) map_pirq = sel_word[{map_pin, 2'b00} +: 3];
    else        map_pirq = rotate_pirq(map_slot, map_pin);
  end

  AST_LOW_SLOTS_UPPER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(map_slot) < OVR_BASE) |-> map_pirq[2]); // R7

  AST_FIXED_SLOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(map_slot) == FIXED_SLOT) |-> (map_pirq[1:0] == map_pin && map_pirq[2])); // R9

endmodule

// File: rtl/pirq_level_merge.sv
module pirq_level_merge
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PIRQ-1:0]      pirq_lvl,
  input  logic                     sci_lvl,
  input  logic [NUM_PIRQ-1:0][7:0] route_q,
  input  logic [2:0]               sci_code,
  input  logic                     sci_gap,
  output logic [PIC_LINES+NUM_PIRQ-1:0] gsi_out
);

  localparam int GSI_W   = PIC_LINES + NUM_PIRQ;
  localparam int FIELD_W = $clog2(PIC_LINES);

  logic [PIC_LINES-1:0] pic_hit;
  logic [GSI_W-1:0]     sci_mask;
  logic [GSI_W-1:0]     gsi_next;
  sci_dest_t            sci_dest;

  always_comb begin
    pic_hit = '0;
    for (int g = 0; g < PIC_LINES; g++) begin
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (pirq_lvl[n] && !route_q[n][7] && route_q[n][FIELD_W-1:0] == FIELD_W'(g))
          pic_hit[g] = 1'b1;
      end
    end
  end

  always_comb begin
    sci_dest = sci_code_dest(sci_code);
    sci_mask = '0;
    if (sci_lvl && !sci_gap && sci_dest.vld && int'(sci_dest.line) < GSI_W)
      sci_mask[sci_dest.line] = 1'b1;
  end

  assign gsi_next = {pirq_lvl, pic_hit} | sci_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsi_out <= '0;
    else        gsi_out <= gsi_next;
  end

  logic unused_route_bits;
  always_comb begin
    unused_route_bits = 1'b0;
    for (int n = 0; n < NUM_PIRQ; n++) unused_route_bits ^= ^route_q[n][6:FIELD_W];
  end

  AST_SCI_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sci_mask)); // R5

  AST_SCI_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sci_gap |=> (gsi_out & ~{pirq_lvl_d, pic_hit_d}) == '0); // R6

  logic [NUM_PIRQ-1:0]  pirq_lvl_d;
  logic [PIC_LINES-1:0] pic_hit_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pirq_lvl_d <= '0;
      pic_hit_d  <= '0;
    end else begin
      pirq_lvl_d <= pirq_lvl;
      pic_hit_d  <= pic_hit;
    end
  end

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic_chk
    AST_APIC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !sci_mask[PIC_LINES+n] |=> gsi_out[PIC_LINES+n] == $past(pirq_lvl[n])); // R2
  end

  for (genvar g = 0; g < PIC_LINES; g++) begin : g_pic_chk
    AST_PIC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!pic_hit[g] && !sci_mask[g]) |=> !gsi_out[g]); // R4
  end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int PIC_LINES  = 16,
  parameter int IDX_W      = 3,
  parameter int OVR_BASE   = 25,
  parameter int OVR_CNT    = 7,
  parameter int FIXED_SLOT = 30,
  localparam int GSI_W     = PIC_LINES + NUM_PIRQ
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [1:0]          cfg_wr_kind,
  input  logic [IDX_W-1:0]    cfg_wr_idx,
  input  logic [15:0]         cfg_wr_data,
  input  logic [NUM_PIRQ-1:0] pirq_lvl,
  input  logic                sci_lvl,
  input  logic [4:0]          map_slot,
  input  logic [1:0]          map_pin,
  output logic [2:0]          map_pirq,
  output logic [GSI_W-1:0]    gsi_out
);

  logic [NUM_PIRQ-1:0][7:0] route_q;
  logic [2:0]               sci_code_q;
  logic                     sci_gap_q;

  pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_kind    (cfg_wr_kind),
    .wr_idx     (cfg_wr_idx),
    .wr_byte    (cfg_wr_data[7:0]),
    .sci_lvl    (sci_lvl),
    .route_q    (route_q),
    .sci_code_q (sci_code_q),
    .sci_gap_q  (sci_gap_q)
  );

  pirq_slot_map #(
    .IDX_W(IDX_W), .OVR_BASE(OVR_BASE), .OVR_CNT(OVR_CNT), .FIXED_SLOT(FIXED_SLOT)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_kind  (cfg_wr_kind),
    .wr_idx   (cfg_wr_idx),
    .wr_data  (cfg_wr_data),
    .map_slot (map_slot),
    .map_pin  (map_pin),
    .map_pirq (map_pirq)
  );

  pirq_level_merge #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pirq_lvl (pirq_lvl),
    .sci_lvl  (sci_lvl),
    .route_q  (route_q),
    .sci_code (sci_code_q),
    .sci_gap  (sci_gap_q),
    .gsi_out  (gsi_out)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> gsi_out == '0); // R1

endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_kind = '0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [15:0] cfg_wr_data = '0;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic [4:0]  map_slot = '0;
  logic [1:0]  map_pin = '0;
  logic [2:0]  map_pirq;
  logic [23:0] gsi_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pirq_router i_pirq_router (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_kind(cfg_wr_kind),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data), .pirq_lvl(pirq_lvl),
    .sci_lvl(sci_lvl), .map_slot(map_slot), .map_pin(map_pin),
    .map_pirq(map_pirq), .gsi_out(gsi_out)
  );

  // {pirq levels, sci level, expected lines}; routes set up before the walk:
  // A->5, B->5, C disabled with field 11, D->3, E..H disabled, SCI code 2 (line 11)
  localparam logic [32:0] VEC [8] = '{
    {8'h01, 1'b0, 24'h010020},
    {8'h02, 1'b0, 24'h020020},
    {8'h04, 1'b0, 24'h040000},
    {8'h08, 1'b0, 24'h080008},
    {8'h00, 1'b1, 24'h000800},
    {8'hF0, 1'b0, 24'hF00000},
    {8'h03, 1'b1, 24'h030820},
    {8'h00, 1'b0, 24'h000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] kind, input logic [2:0] idx, input logic [15:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_kind = kind; cfg_wr_idx = idx; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic lookup(input string req, input int slot, input int pin, input int exp);
    map_slot = 5'(slot); map_pin = 2'(pin);
    #1;
    check(req, 32'(map_pirq), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset lines idle", 32'(gsi_out), 32'h0);

    // R1 R3: disabled route bytes leave only the high line; SCI defaults to line 9
    pirq_lvl = 8'h01; sci_lvl = 1'b1;
    @(negedge clk);
    check("R1 R3 reset routing", 32'(gsi_out), 32'h010200);
    pirq_lvl = '0; sci_lvl = 1'b0;

    // slot lookups at reset values
    lookup("R7 slot0 INTA", 0, 0, 4);
    lookup("R7 slot5 INTC", 5, 2, 7);
    lookup("R7 slot24 INTD", 24, 3, 7);
    lookup("R1 R8 slot25 reset INTB", 25, 1, 1);
    lookup("R9 slot30 INTB", 30, 1, 5);

    cfg_write(2'd2, 3'd2, 16'h0567);
    lookup("R8 slot27 INTA", 27, 0, 7);
    lookup("R8 slot27 INTC", 27, 2, 5);
    lookup("R8 slot27 INTD", 27, 3, 0);
    cfg_write(2'd2, 3'd5, 16'h0000);
    lookup("R9 slot30 write ignored", 30, 1, 5);
    cfg_write(2'd2, 3'd7, 16'h0000);
    lookup("R9 idx7 write ignored", 31, 2, 2);

    // route setup for the table walk
    cfg_write(2'd0, 3'd0, 16'h0005);
    cfg_write(2'd0, 3'd1, 16'h0005);
    cfg_write(2'd0, 3'd2, 16'h008B);
    cfg_write(2'd0, 3'd3, 16'h0003);
    cfg_write(2'd1, 3'd0, 16'h0002);

    for (int v = 0; v < 8; v++) begin
      pirq_lvl = VEC[v][32:25];
      sci_lvl  = VEC[v][24];
      @(negedge clk);
      check($sformatf("R2 R4 R5 vector %0d", v), 32'(gsi_out), 32'(VEC[v][23:0]));
    end

    // R6: move the asserted SCI from line 11 to line 20
    pirq_lvl = '0; sci_lvl = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 SCI on line 11", 32'(gsi_out), 32'h000800);
    cfg_write(2'd1, 3'd0, 16'h0004);
    check("R6 old line one more clock", 32'(gsi_out), 32'h000800);
    @(negedge clk);
    check("R6 gap clock", 32'(gsi_out), 32'h0);
    @(negedge clk);
    check("R6 new line 20", 32'(gsi_out), 32'h100000);

    // R5: reserved code steers nowhere, then move to line 10
    cfg_write(2'd1, 3'd0, 16'h0003);
    repeat (2) @(negedge clk);
    check("R5 reserved code no line", 32'(gsi_out), 32'h0);
    cfg_write(2'd1, 3'd0, 16'h0001);
    repeat (2) @(negedge clk);
    check("R5 code 1 line 10", 32'(gsi_out), 32'h000400);

    // R4: re-enable PIRQ C onto line 5, sharing with A
    sci_lvl = 1'b0;
    cfg_write(2'd0, 3'd2, 16'h0005);
    pirq_lvl = 8'h05;
    @(negedge clk);
    check("R4 shared line 5", 32'(gsi_out), 32'h050020);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule